// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block is an 18-bit first-in first-out buffer whose write side and read side each run on their own clock, so producers and consumers in unrelated clock domains can exchange words, with writing and reading going on at the same time. Depth is a power-of-two parameter. Pointers cross between the domains as Gray code through two-flop synchronisers. Full and almost-full are worked out on the write side. Empty and almost-empty are worked out on the read side.

A mode input, captured while master reset is low, picks one of two output timings. In standard timing, each word needs a read strobe and the status pins act as empty and full. In fall-through timing, the oldest word appears on the output by itself, and the status pins act as output-ready and input-ready. Two thresholds drive the almost-empty and almost-full flags. After master reset they hold a preset value chosen by a 3-bit select. Either a bit-serial path or a parallel path on the data bus can rewrite them. Partial reset empties the buffer but keeps the thresholds and the mode. A retransmit input restarts reading from the first location written since the last reset.

Top module: `dc_prog_fifo`

## Requirements
- R1: Words written on `wclk` are read out on `rclk` in write order, with no loss or duplication, while both ports stream at the same time.
- R2: In standard timing (mode 0), `rd_stat` is 1 exactly when no word is stored. A read strobe accepted at an `rclk` edge while `rd_stat` is 0 puts the oldest word on `rdata` at that same edge.
- R3: In fall-through timing (mode 1), `rd_stat` is 1 when `rdata` holds a valid word. The oldest word is placed on `rdata` without any read strobe. A read strobe while `rd_stat` is 1 consumes that word.
- R4: In standard timing, `wr_stat` is 1 when DEPTH words are stored in the array. In fall-through timing, `wr_stat` is 1 when the array has room for at least one word.
- R5: A write while the array is full, and a read while it is empty, have no effect on pointers, stored data or `rdata`.
- R6: While `mrst_n` is 0, the buffer is emptied, `mode_fwft` is captured, and both thresholds become 2*`ofs_sel`+1.
- R7: While `prst_n` is 0, the buffer is emptied, and the thresholds and the captured mode keep their values.
- R8: `half_full` is 1 when more than DEPTH/2 words are in the array.
- R9: `almost_empty` is 1 when the number of words in the array is at or below the empty threshold. In fall-through timing, a word already moved to `rdata` is not counted.
- R10: `almost_full` is 1 when the free space in the array is at or below the full threshold.
- R11: With `ld` high, `wdata[AW-1:0]` (AW = log2 DEPTH) is loaded into the empty threshold on the first strobe after a reset and into the full threshold on the second, alternating after that. No word is written while `ld` is high.
- R12: With `ser_en` high and `ld` low, one bit of `ser_in` is taken per `wclk`, least significant bit first: AW bits of the empty threshold, then AW bits of the full threshold. No word is written while `ser_en` is high.
- R13: A one-cycle `rtx` returns reading to the first location written since reset. In standard timing, the next accepted read yields that word. In fall-through timing, that word is on `rdata` with `rd_stat` 1 at the same `rclk` edge that takes `rtx`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, active low, synchronous in each domain |
| prst_n | input | 1 | Partial reset, active low, synchronous in each domain |
| mode_fwft | input | 1 | Timing mode sampled during master reset (1 = fall-through) |
| ofs_sel | input | 3 | Threshold preset select sampled during master reset |
| wen | input | 1 | Write strobe |
| wdata | input | 18 | Write data, also parallel threshold value |
| ld | input | 1 | Parallel threshold load strobe |
| ser_en | input | 1 | Serial threshold shift enable |
| ser_in | input | 1 | Serial threshold data bit |
| ren | input | 1 | Read strobe |
| rtx | input | 1 | Retransmit request |
| rdata | output | 18 | Read data register |
| rd_stat | output | 1 | Empty (standard) or output-ready (fall-through) |
| wr_stat | output | 1 | Full (standard) or input-ready (fall-through) |
| half_full | output | 1 | More than half the depth in use |
| almost_empty | output | 1 | Word count at or below empty threshold |
| almost_full | output | 1 | Free space at or below full threshold |

## Verification
A write on `wclk` and a read on `rclk` can land on the same stored word: the writer is still filling the array while the reader is draining it, and the empty and full boundaries move in both domains at once. The bench sets this up by running a flow-controlled writer and reader side by side over many more words than the depth, using clocks of unequal period, so edges slide against each other. The scoreboard compares every word the read side delivers with the word queued at write time. Any word that is dropped, repeated or reordered at a boundary shows up as a mismatch or as entries left in the queue.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
// Package: shared word type and the threshold preset rule for the
// dual-clock programmable-flag FIFO. Assumes an 18-bit data path.
package dcf_pkg;
    localparam int DATA_W = 18;
    typedef logic [DATA_W-1:0] word_t;

    // Preset threshold chosen by the 3-bit select at master reset.
    function automatic int unsigned preset_ofs(input logic [2:0] sel);
        return 2 * int'(sel) + 1;
    endfunction
endpackage

// File: rtl/dcf_sync.sv
`timescale 1ns/1ps
// Two-flop synchroniser for a Gray-coded pointer.
// Assumes that at most one bit of d changes between source clock edges.
module dcf_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two register stages into the destination domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/dcf_offsets.sv
`timescale 1ns/1ps
// Threshold registers for almost-empty and almost-full, in the write domain.
// Master reset loads the preset. Partial reset only restarts the load
// sequencing. The read domain treats ae_ofs as quasi-static: it is only
// changed while the FIFO is idle.
module dcf_offsets #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic [2:0]    sel,
    input  logic          ld,
    input  logic [AW-1:0] ld_val,
    input  logic          ser_en,
    input  logic          ser_in,
    output logic [AW-1:0] ae_ofs,
    output logic [AW-1:0] af_ofs
);
    localparam int NBITS = 2 * AW;
    localparam int SW    = $clog2(NBITS);

    logic          ld_second;
    logic [SW-1:0] bit_idx;

    // Preset, parallel alternation and serial shifting of both thresholds.
    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            ae_ofs    <= AW'(dcf_pkg::preset_ofs(sel));
            af_ofs    <= AW'(dcf_pkg::preset_ofs(sel));
            ld_second <= 1'b0;
            bit_idx   <= '0;
        end else if (!prst_n) begin
            ld_second <= 1'b0;
            bit_idx   <= '0;
        end else if (ld) begin
            if (!ld_second) ae_ofs <= ld_val;
            else            af_ofs <= ld_val;
            ld_second <= ~ld_second;
        end else if (ser_en) begin
            for (int i = 0; i < AW; i++) begin
                if (bit_idx == SW'(i))      ae_ofs[i] <= ser_in;
                if (bit_idx == SW'(i + AW)) af_ofs[i] <= ser_in;
            end
            bit_idx <= (bit_idx == SW'(NBITS - 1)) ? '0 : bit_idx + SW'(1);
        end
    end
endmodule

// File: rtl/dcf_wr_ctrl.sv
`timescale 1ns/1ps
// Write-side control: write pointer, full, almost-full and half-full.
// Works on a synchronised copy of the read pointer, so the flags are
// pessimistic for the synchroniser latency.
module dcf_wr_ctrl #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wen,
    input  logic          hold,
    input  logic [AW:0]   rgray_s,
    input  logic [AW-1:0] af_ofs,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wbin,
    output logic [AW:0]   wgray,
    output logic          full,
    output logic          almost_full,
    output logic          half_full
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    logic [PW-1:0] rbin_s, count, free, wbin_nx;

    // Convert the synchronised Gray read pointer back to binary.
    always_comb begin
        for (int i = 0; i < PW; i++) rbin_s[i] = ^(rgray_s >> i);
    end

    // Occupancy, flag decode and write qualification.
    always_comb begin
        count       = wbin - rbin_s;
        free        = PW'(DEPTH) - count;
        full        = (count == PW'(DEPTH));
        almost_full = (free <= {1'b0, af_ofs});
        half_full   = (count > PW'(DEPTH / 2));
        we          = wen && !hold && !full;
        wbin_nx     = we ? wbin + PW'(1) : wbin;
    end

    assign waddr = wbin[AW-1:0];

    // Register the binary and Gray forms of the write pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else begin
            wbin  <= wbin_nx;
            wgray <= wbin_nx ^ (wbin_nx >> 1);
        end
    end
endmodule

// File: rtl/dcf_rd_ctrl.sv
`timescale 1ns/1ps
// Read-side control: read pointer, empty, almost-empty, output register
// and retransmit. Handles standard timing and fall-through timing.
// Assumes the write pointer has not wrapped when retransmit is used.
module dcf_rd_ctrl #(
    parameter int AW = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fwft,
    input  logic                 ren,
    input  logic                 rtx,
    input  logic [AW:0]          wgray_s,
    input  logic [AW-1:0]        ae_ofs,
    input  dcf_pkg::word_t       mem_q,
    output logic [AW-1:0]        raddr,
    output logic [AW:0]          rbin,
    output logic [AW:0]          rgray,
    output dcf_pkg::word_t       rdata,
    output logic                 rd_stat,
    output logic                 empty,
    output logic                 almost_empty
);
    localparam int PW = AW + 1;

    logic [PW-1:0] wbin_s, count, rbin_nx;
    logic          ov, ov_nx, load;

    // Convert the synchronised Gray write pointer back to binary.
    always_comb begin
        for (int i = 0; i < PW; i++) wbin_s[i] = ^(wgray_s >> i);
    end

    // Occupancy of the array and the read-side flags.
    always_comb begin
        count        = wbin_s - rbin;
        empty        = (count == '0);
        almost_empty = (count <= {1'b0, ae_ofs});
    end

    // Next read pointer, output-valid and register-load decision.
    always_comb begin
        rbin_nx = rbin;
        ov_nx   = ov;
        load    = 1'b0;
        if (rtx) begin
            if (fwft && wbin_s != '0) begin
                rbin_nx = PW'(1);
                ov_nx   = 1'b1;
                load    = 1'b1;
            end else begin
                rbin_nx = '0;
                ov_nx   = 1'b0;
            end
        end else if (fwft) begin
            if ((!ov || ren) && !empty) begin
                rbin_nx = rbin + PW'(1);
                ov_nx   = 1'b1;
                load    = 1'b1;
            end else if (ren) begin
                ov_nx = 1'b0;
            end
        end else if (ren && !empty) begin
            rbin_nx = rbin + PW'(1);
            load    = 1'b1;
        end
    end

    assign raddr   = rtx ? '0 : rbin[AW-1:0];
    assign rd_stat = fwft ? ov : empty;

    // Pointer, Gray copy, output-valid and output data registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbin  <= '0;
            rgray <= '0;
            ov    <= 1'b0;
            rdata <= '0;
        end else begin
            rbin  <= rbin_nx;
            rgray <= rbin_nx ^ (rbin_nx >> 1);
            ov    <= ov_nx;
            if (load) rdata <= mem_q;
        end
    end
endmodule

// File: rtl/dc_prog_fifo.sv
`timescale 1ns/1ps
// Dual-clock FIFO with programmable almost-empty/almost-full thresholds,
// two output timing modes, two reset types and retransmit.
// Assumes DEPTH is a power of two of at least 16, and that both resets
// are held low for several cycles of the slower clock.
module dc_prog_fifo #(
    parameter int DEPTH = 16
) (
    input  logic                  wclk,
    input  logic                  rclk,
    input  logic                  mrst_n,
    input  logic                  prst_n,
    input  logic                  mode_fwft,
    input  logic [2:0]            ofs_sel,
    input  logic                  wen,
    input  logic [17:0]           wdata,
    input  logic                  ld,
    input  logic                  ser_en,
    input  logic                  ser_in,
    input  logic                  ren,
    input  logic                  rtx,
    output logic [17:0]           rdata,
    output logic                  rd_stat,
    output logic                  wr_stat,
    output logic                  half_full,
    output logic                  almost_empty,
    output logic                  almost_full
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic           rst_n;
    logic           fwft_w, fwft_r;
    logic [AW-1:0]  ae_ofs, af_ofs, waddr, raddr;
    logic [PW-1:0]  wbin, wgray, rbin, rgray, wgray_s, rgray_s;
    logic           we, wr_full, rd_empty;
    dcf_pkg::word_t mem [DEPTH];
    dcf_pkg::word_t mem_q;

    assign rst_n = mrst_n & prst_n;

    // Capture the timing mode in the write domain during master reset.
    always_ff @(posedge wclk) begin
        if (!mrst_n) fwft_w <= mode_fwft;
    end

    // Capture the timing mode in the read domain during master reset.
    always_ff @(posedge rclk) begin
        if (!mrst_n) fwft_r <= mode_fwft;
    end

    dcf_offsets #(.AW(AW)) u_ofs (
        .clk    (wclk),
        .mrst_n (mrst_n),
        .prst_n (prst_n),
        .sel    (ofs_sel),
        .ld     (ld),
        .ld_val (wdata[AW-1:0]),
        .ser_en (ser_en),
        .ser_in (ser_in),
        .ae_ofs (ae_ofs),
        .af_ofs (af_ofs)
    );

    dcf_sync #(.W(PW)) u_r2w (
        .clk   (wclk),
        .rst_n (rst_n),
        .d     (rgray),
        .q     (rgray_s)
    );

    dcf_sync #(.W(PW)) u_w2r (
        .clk   (rclk),
        .rst_n (rst_n),
        .d     (wgray),
        .q     (wgray_s)
    );

    dcf_wr_ctrl #(.AW(AW)) u_wr (
        .clk         (wclk),
        .rst_n       (rst_n),
        .wen         (wen),
        .hold        (ld | ser_en),
        .rgray_s     (rgray_s),
        .af_ofs      (af_ofs),
        .we          (we),
        .waddr       (waddr),
        .wbin        (wbin),
        .wgray       (wgray),
        .full        (wr_full),
        .almost_full (almost_full),
        .half_full   (half_full)
    );

    // Storage array: synchronous write, combinational read.
    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign mem_q = mem[raddr];

    dcf_rd_ctrl #(.AW(AW)) u_rd (
        .clk          (rclk),
        .rst_n        (rst_n),
        .fwft         (fwft_r),
        .ren          (ren),
        .rtx          (rtx),
        .wgray_s      (wgray_s),
        .ae_ofs       (ae_ofs),
        .mem_q        (mem_q),
        .raddr        (raddr),
        .rbin         (rbin),
        .rgray        (rgray),
        .rdata        (rdata),
        .rd_stat      (rd_stat),
        .empty        (rd_empty),
        .almost_empty (almost_empty)
    );

    assign wr_stat = fwft_w ? !wr_full : wr_full;
endmodule

// File: rtl/dcf_fifo_chk.sv
`timescale 1ns/1ps
// Assertion checker for dc_prog_fifo, attached with bind below.
module dcf_fifo_chk #(
    parameter int AW = 4
) (
    input logic        wclk,
    input logic        rclk,
    input logic        mrst_n,
    input logic        prst_n,
    input logic        wen,
    input logic        ld,
    input logic        ser_en,
    input logic        ren,
    input logic        rtx,
    input logic        fwft_r,
    input logic        wr_full,
    input logic        rd_empty,
    input logic        half_full,
    input logic        almost_full,
    input logic        almost_empty,
    input logic [AW:0] wbin,
    input logic [AW:0] rbin
);
    logic live;
    assign live = mrst_n && prst_n;

    AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!live)
        (wr_full && wen) |=> $stable(wbin)); // R5
    AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (!live)
        (!fwft_r && rd_empty && ren && !rtx) |=> $stable(rbin)); // R5
    AST_HALF_WHEN_FULL: assert property (@(posedge wclk) disable iff (!live)
        wr_full |-> half_full); // R8
    AST_AF_WHEN_FULL: assert property (@(posedge wclk) disable iff (!live)
        wr_full |-> almost_full); // R10
    AST_AE_WHEN_EMPTY: assert property (@(posedge rclk) disable iff (!live)
        rd_empty |-> almost_empty); // R9
    AST_PLOAD_NO_WRITE: assert property (@(posedge wclk) disable iff (!live)
        ld |=> $stable(wbin)); // R11
    AST_SLOAD_NO_WRITE: assert property (@(posedge wclk) disable iff (!live)
        ser_en |=> $stable(wbin)); // R12
    AST_RTX_STD: assert property (@(posedge rclk) disable iff (!live)
        (!fwft_r && rtx) |=> (rbin == '0)); // R13
endmodule

bind dc_prog_fifo dcf_fifo_chk #(.AW(AW)) u_chk (
    .wclk         (wclk),
    .rclk         (rclk),
    .mrst_n       (mrst_n),
    .prst_n       (prst_n),
    .wen          (wen),
    .ld           (ld),
    .ser_en       (ser_en),
    .ren          (ren),
    .rtx          (rtx),
    .fwft_r       (fwft_r),
    .wr_full      (wr_full),
    .rd_empty     (rd_empty),
    .half_full    (half_full),
    .almost_full  (almost_full),
    .almost_empty (almost_empty),
    .wbin         (wbin),
    .rbin         (rbin)
);

// File: tb/dc_prog_fifo_test.sv
`timescale 1ns/1ps
// Scoreboard bench: writer tasks queue expected words, a read-side
// monitor pops and compares each word the design delivers.
module dc_prog_fifo_test;
    localparam int DEPTH = 16;
    localparam int AW    = 4;

    logic        wclk = 0, rclk = 0;
    logic        mrst_n = 0, prst_n = 1, mode_fwft = 0;
    logic [2:0]  ofs_sel = 3'd2;
    logic        wen = 0, ld = 0, ser_en = 0, ser_in = 0, ren = 0, rtx = 0;
    logic [17:0] wdata = '0;
    logic [17:0] rdata;
    logic        rd_stat, wr_stat, half_full, almost_empty, almost_full;

    int          n_chk = 0, n_fail = 0, seq = 0;
    bit          fwft_tb = 0, pend = 0;
    logic [17:0] sb[$];
    logic [17:0] hist[$];

    always #2 wclk = ~wclk;   // 250 MHz write clock
    always #3 rclk = ~rclk;   // read clock of unequal period

    dc_prog_fifo #(.DEPTH(DEPTH)) uut (
        .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
        .mode_fwft(mode_fwft), .ofs_sel(ofs_sel), .wen(wen), .wdata(wdata),
        .ld(ld), .ser_en(ser_en), .ser_in(ser_in), .ren(ren), .rtx(rtx),
        .rdata(rdata), .rd_stat(rd_stat), .wr_stat(wr_stat),
        .half_full(half_full), .almost_empty(almost_empty),
        .almost_full(almost_full)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [17:0] next_val();
        seq++;
        return 18'((seq * 7919 + 13) & 18'h3FFFF);
    endfunction

    // Monitor: compares every delivered word against the scoreboard (R1 R2 R3).
    always @(negedge rclk) begin
        if (mrst_n && prst_n) begin
            if (fwft_tb) begin
                if (ren && rd_stat && !rtx) begin
                    if (sb.size() == 0) chk("R3 unexpected word", int'(rdata), -1);
                    else chk("R1 R3 data order", int'(rdata), int'(sb.pop_front()));
                end
            end else begin
                if (pend) begin
                    if (sb.size() == 0) chk("R2 unexpected word", int'(rdata), -1);
                    else chk("R1 R2 data order", int'(rdata), int'(sb.pop_front()));
                end
                pend = ren && !rd_stat && !rtx;
            end
        end else begin
            pend = 0;
        end
    end

    task automatic settle();
        repeat (10) @(posedge rclk);
        @(negedge rclk);
    endtask

    task automatic do_reset(bit master, bit fw, logic [2:0] sel);
        @(posedge wclk); #1;
        if (master) begin
            mrst_n = 0; mode_fwft = fw; ofs_sel = sel; fwft_tb = fw;
        end else prst_n = 0;
        repeat (4) @(posedge rclk);
        #1 mrst_n = 1; prst_n = 1;
        sb.delete(); hist.delete();
        settle();
    endtask

    // Driver: flow-controlled writer, queues each accepted word.
    task automatic wr_stream(int n);
        int issued;
        issued = 0;
        while (issued < n) begin
            @(posedge wclk); #1;
            if (fwft_tb ? wr_stat : !wr_stat) begin
                wen = 1; wdata = next_val();
                sb.push_back(wdata); hist.push_back(wdata);
                issued++;
            end else wen = 0;
        end
        @(posedge wclk); #1 wen = 0;
    endtask

    // Single write that the design is expected to drop.
    task automatic wr_raw(logic [17:0] v);
        @(posedge wclk); #1 wen = 1; wdata = v;
        @(posedge wclk); #1 wen = 0;
    endtask

    // Flow-controlled reader issuing exactly n accepted reads.
    task automatic rd_stream(int n);
        int issued;
        issued = 0;
        while (issued < n) begin
            @(posedge rclk); #1;
            if (fwft_tb ? rd_stat : !rd_stat) begin
                ren = 1; issued++;
            end else ren = 0;
        end
        @(posedge rclk); #1 ren = 0;
        repeat (3) @(posedge rclk);
    endtask

    task automatic pload(logic [AW-1:0] v);
        @(posedge wclk); #1 ld = 1; wen = 1; wdata = 18'(v);
        @(posedge wclk); #1 ld = 0; wen = 0;
    endtask

    task automatic sload(logic [AW-1:0] ae, logic [AW-1:0] af);
        for (int i = 0; i < 2 * AW; i++) begin
            @(posedge wclk); #1 ser_en = 1; wen = 1;
            ser_in = (i < AW) ? ae[i] : af[i - AW];
        end
        @(posedge wclk); #1 ser_en = 0; wen = 0;
    endtask

    task automatic retransmit();
        @(posedge rclk); #1 rtx = 1;
        @(posedge rclk); #1 rtx = 0;
        sb = hist;
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // Standard timing, preset select 2 -> thresholds 5.
        do_reset(1, 0, 3'd2);
        chk("R6 R2 empty after master reset", rd_stat, 1);
        chk("R4 not full after reset", wr_stat, 0);
        chk("R8 half_full after reset", half_full, 0);
        chk("R6 R9 almost_empty after reset", almost_empty, 1);
        chk("R10 almost_full after reset", almost_full, 0);
        wr_stream(5); settle();
        chk("R9 ae at 5 words", almost_empty, 1);
        wr_stream(1); settle();
        chk("R9 ae at 6 words", almost_empty, 0);
        wr_stream(2); settle();
        chk("R8 hf at 8 words", half_full, 0);
        wr_stream(1); settle();
        chk("R8 hf at 9 words", half_full, 1);
        wr_stream(1); settle();
        chk("R10 af at free 6", almost_full, 0);
        wr_stream(1); settle();
        chk("R10 af at free 5", almost_full, 1);
        wr_stream(5); settle();
        chk("R4 full at DEPTH", wr_stat, 1);
        wr_raw(18'h3ABCD);           // dropped write, R5
        rd_stream(DEPTH); settle();
        chk("R5 R2 no extra word", sb.size(), 0);
        chk("R2 empty after drain", rd_stat, 1);
        begin
            logic [17:0] last;
            last = rdata;
            @(posedge rclk); #1 ren = 1;
            @(posedge rclk); #1 ren = 0;
            settle();
            chk("R5 read on empty keeps rdata", int'(rdata), int'(last));
            chk("R5 still empty", rd_stat, 1);
        end

        // Parallel load: empty 3, full 2.
        pload(4'd3); pload(4'd2); settle();
        chk("R11 load writes nothing", rd_stat, 1);
        wr_stream(3); settle();
        chk("R11 ae at 3 words", almost_empty, 1);
        wr_stream(1); settle();
        chk("R11 ae at 4 words", almost_empty, 0);
        wr_stream(9); settle();
        chk("R11 af at free 3", almost_full, 0);
        wr_stream(1); settle();
        chk("R11 af at free 2", almost_full, 1);

        // Partial reset keeps thresholds.
        do_reset(0, 0, 3'd0);
        chk("R7 empty after partial reset", rd_stat, 1);
        wr_stream(3); settle();
        chk("R7 ae kept at 3", almost_empty, 1);
        wr_stream(1); settle();
        chk("R7 ae kept at 4", almost_empty, 0);

        // Serial load: empty 7, full 1.
        do_reset(0, 0, 3'd0);
        sload(4'd7, 4'd1); settle();
        chk("R12 load writes nothing", rd_stat, 1);
        wr_stream(7); settle();
        chk("R12 ae at 7 words", almost_empty, 1);
        wr_stream(1); settle();
        chk("R12 ae at 8 words", almost_empty, 0);
        wr_stream(6); settle();
        chk("R12 af at free 2", almost_full, 0);
        wr_stream(1); settle();
        chk("R12 af at free 1", almost_full, 1);

        // Concurrent streaming across both clocks.
        do_reset(0, 0, 3'd0);
        fork
            wr_stream(60);
            rd_stream(60);
        join
        settle();
        chk("R1 all words delivered", sb.size(), 0);

        // Retransmit in standard timing.
        do_reset(0, 0, 3'd0);
        wr_stream(5); settle();
        rd_stream(3);
        retransmit();
        rd_stream(5); settle();
        chk("R13 std replay complete", sb.size(), 0);

        // Fall-through timing, preset select 0 -> thresholds 1.
        do_reset(1, 1, 3'd0);
        chk("R3 no word after reset", rd_stat, 0);
        chk("R4 input-ready after reset", wr_stat, 1);
        wr_stream(1); settle();
        chk("R3 word ready without read", rd_stat, 1);
        chk("R3 word on rdata", int'(rdata), int'(sb[0]));
        rd_stream(1);
        wr_stream(15); settle();
        chk("R6 af default at free 2", almost_full, 0);
        wr_stream(1); settle();
        chk("R6 af default at free 1", almost_full, 1);
        wr_stream(1); settle();
        chk("R4 no room when array full", wr_stat, 0);
        rd_stream(17); settle();
        chk("R3 fall-through drain", sb.size(), 0);

        // Partial reset keeps the mode; retransmit in fall-through timing.
        do_reset(0, 0, 3'd0);
        chk("R7 mode kept, no word", rd_stat, 0);
        chk("R7 mode kept, input-ready", wr_stat, 1);
        wr_stream(4); settle();
        rd_stream(2);
        retransmit();
        chk("R13 first word at once", int'(rdata), int'(hist[0]));
        chk("R13 output ready at once", rd_stat, 1);
        rd_stream(4); settle();
        chk("R13 fall-through replay complete", sb.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule